// File: doc/BRIEF.md
# Cyclic Unit-Element Shuffler for a Capacitive DAC

This block sits between the successive-approximation logic and the most significant part of a capacitive DAC. Only the upper control bits are shuffled. Each of these bits is weighted by a power of two, and that weight is realised as a set of equal unit elements, 31 of them for five bits. The lower DAC bits bypass the block.

The elements that belong to one bit form a contiguous run. The runs are laid end to end around a ring, largest first, beginning at a start position. That position comes from a pseudo-random pointer, which moves once per conversion. Static mismatch between unit elements therefore appears as noise rather than as a fixed nonlinearity.

The rotation is built as a logarithmic barrel shifter. It has one multiplexer level per pointer bit, and the level for pointer bit n turns the ring by 2^n places. Shuffling can be switched off, and then every bit drives a fixed group of elements.

Top module: `cyclic_dem_selector`

## Requirements
- R1: While `rst_n` is low, every `unit_o` line is 0. The pointer state starts at the nonzero seed, which is 1 by default.
- R2: The pointer is a 5-bit shift register. On each step it moves one place toward the MSB, and bit 0 takes bit 4 XOR bit 2. It steps once per cycle in which `start_i` is high at the clock edge. Its states are never zero, and from any state it returns to that state after exactly 31 steps, having visited all 31 nonzero values.
- R3: With `start_i` low the pointer holds its value, so the element allotment for a given control word does not change during a conversion.
- R4: The number of asserted `unit_o` lines equals 16·msb_i[4] + 8·msb_i[3] + 4·msb_i[2] + 2·msb_i[1] + msb_i[0], using the control word sampled at the previous edge.
- R5: With `dem_en_i` low, the unrotated allotment is used. Elements 0–15 follow msb_i[4], 16–23 follow msb_i[3], 24–27 follow msb_i[2], 28–29 follow msb_i[1], and 30 follows msb_i[0].
- R6: With `dem_en_i` high and pointer value p, line j carries the unrotated line (j − p) mod 31.
- R7: The output is registered. `unit_o` after an edge reflects `msb_i` and `dem_en_i` at that edge, together with the pointer value held before that edge. A pointer step caused by `start_i` therefore first affects the control word sampled one edge later.
- R8: Rotation wraps modulo 31. A run that passes line 30 continues at line 0, and pointer value 31 gives the same allotment as no rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_i | input | 1 | Conversion-start strobe; advances the pointer |
| dem_en_i | input | 1 | 1 = shuffle, 0 = fixed allotment |
| msb_i | input | 5 | Upper DAC control bits, bit 4 most significant |
| unit_o | output | 31 | Unit-element drive lines, registered |

## Verification
The bench builds the block with its default parameters: five shuffled bits, 31 elements and the seed of 1. With these values the whole pointer cycle takes only 31 conversion strobes. Walking it with a single-element control word therefore shows every rotation amount, including the wrap past line 30 and the all-ones state that must act as no rotation. All-ones and all-zero control words, mode changes between cycles, and strobes arriving together with new control words check the one-cycle latency of the pointer against the register stage.

// File: rtl/dem_pkg.sv
package dem_pkg;

  // Number of unit elements for a given count of shuffled bits.
  function automatic int unsigned unit_count(input int unsigned nbits);
    return (1 << nbits) - 1;
  endfunction

  // First unit element of the run for control bit b (larger runs come first).
  function automatic int unsigned run_first(input int unsigned nbits, input int unsigned b);
    return (1 << nbits) - (1 << (b + 1));
  endfunction

  // Length of the run for control bit b.
  function automatic int unsigned run_len(input int unsigned b);
    return 1 << b;
  endfunction

  // Binary weight of a control word (used by checks).
  function automatic int unsigned word_weight(input logic [31:0] w, input int unsigned nbits);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < nbits; i++) begin
      if (w[i]) acc += (1 << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/dem_lfsr.sv
module dem_lfsr #(
  parameter int unsigned        W    = 5,
  parameter logic [W-1:0]       TAPS = 5'b10100,
  parameter logic [W-1:0]       SEED = 5'b00001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (step_i) state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: the shift register never reaches the all-zero lock-up state
  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R3: no strobe, no pointer movement
  assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(state_q));

endmodule

// File: rtl/dem_weight_map.sv
module dem_weight_map #(
  parameter int unsigned NB = 5,
  localparam int unsigned NE = dem_pkg::unit_count(NB)
) (
  input  logic [NB-1:0] ctrl_i,
  output logic [NE-1:0] base_o
);

  for (genvar b = 0; b < NB; b++) begin : g_bit
    localparam int unsigned FIRST = dem_pkg::run_first(NB, b);
    localparam int unsigned LEN   = dem_pkg::run_len(b);
    for (genvar k = 0; k < LEN; k++) begin : g_unit
      assign base_o[FIRST + k] = ctrl_i[b];
    end
  end

endmodule

// File: rtl/dem_rotator.sv
module dem_rotator #(
  parameter int unsigned NB = 5,
  localparam int unsigned NE = dem_pkg::unit_count(NB)
) (
  input  logic [NE-1:0] vec_i,
  input  logic [NB-1:0] amt_i,
  output logic [NE-1:0] vec_o
);

  logic [NE-1:0] stage [NB+1];

  assign stage[0] = vec_i;

  // Level lv turns the ring of NE lines by 2^lv places (mod NE).
  for (genvar lv = 0; lv < NB; lv++) begin : g_level
    localparam int unsigned SH = (1 << lv) % NE;
    logic [NE-1:0] turned;
    assign turned        = {stage[lv][NE-1-SH:0], stage[lv][NE-1:NE-SH]};
    assign stage[lv + 1] = amt_i[lv] ? turned : stage[lv];
  end

  assign vec_o = stage[NB];

endmodule

// File: rtl/cyclic_dem_selector.sv
module cyclic_dem_selector #(
  parameter int unsigned     NDEM = 5,
  parameter logic [NDEM-1:0] TAPS = 5'b10100,
  parameter logic [NDEM-1:0] SEED = 5'b00001,
  localparam int unsigned    NE   = dem_pkg::unit_count(NDEM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dem_en_i,
  input  logic [NDEM-1:0] msb_i,
  output logic [NE-1:0]   unit_o
);

  logic [NDEM-1:0] ptr;
  logic [NDEM-1:0] amt;
  logic [NE-1:0]   base;
  logic [NE-1:0]   unit_d;
  logic [NE-1:0]   unit_q;

  dem_lfsr #(.W(NDEM), .TAPS(TAPS), .SEED(SEED)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (start_i),
    .state_o (ptr)
  );

  dem_weight_map #(.NB(NDEM)) u_map (
    .ctrl_i (msb_i),
    .base_o (base)
  );

  assign amt = dem_en_i ? ptr : '0;

  dem_rotator #(.NB(NDEM)) u_rot (
    .vec_i (base),
    .amt_i (amt),
    .vec_o (unit_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unit_q <= '0;
    else        unit_q <= unit_d;
  end

  assign unit_o = unit_q;

  // One cycle after reset the output register holds a sampled word.
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R4: element count equals the binary weight of the sampled word
  assert_unit_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> $countones(unit_o) == $past(dem_pkg::word_weight(32'(msb_i), NDEM)));

  // R5: with shuffling off the fixed allotment reaches the lines
  assert_fixed_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(!dem_en_i)) |-> unit_o == $past(base));

  // R8: an all-ones pointer is a full turn of the ring
  assert_full_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(dem_en_i) && $past(ptr == '1)) |-> unit_o == $past(base));

endmodule

// File: tb/cyclic_dem_selector_bench.sv
`timescale 1ns/1ps
module cyclic_dem_selector_bench;

  localparam int NB = 5;
  localparam int NE = 31;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          dem_en_i;
  logic [NB-1:0] msb_i;
  logic [NE-1:0] unit_o;

  int checks = 0;
  int errors = 0;

  logic [NB-1:0] ptr_m;
  logic [NE-1:0] exp_v;

  always #2.5 clk = ~clk;

  cyclic_dem_selector u_cyclic_dem_selector (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .dem_en_i (dem_en_i),
    .msb_i    (msb_i),
    .unit_o   (unit_o)
  );

  // Which control bit owns unrotated line i (R5 layout).
  function automatic int owner(input int i);
    if (i < 16) return 4;
    if (i < 24) return 3;
    if (i < 28) return 2;
    if (i < 30) return 1;
    return 0;
  endfunction

  function automatic logic [NE-1:0] model(input logic [NB-1:0] c, input int p);
    logic [NE-1:0] r;
    for (int j = 0; j < NE; j++) begin
      int src;
      src  = (((j - (p % NE)) % NE) + NE) % NE;
      r[j] = c[owner(src)];
    end
    return r;
  endfunction

  function automatic logic [NB-1:0] ptr_next(input logic [NB-1:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  task automatic check_eq(input logic [NE-1:0] act, input logic [NE-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: unit_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare at next falling edge.
  task automatic step(input logic [NB-1:0] c, input logic s, input logic e, input string tag);
    logic [NE-1:0] nxt;
    msb_i    = c;
    start_i  = s;
    dem_en_i = e;
    nxt      = model(c, e ? int'(ptr_m) : 0);
    @(posedge clk);
    if (s) ptr_m = ptr_next(ptr_m);
    exp_v = nxt;
    @(negedge clk);
    check_eq(unit_o, exp_v, tag);
    check_int($countones(unit_o), 16*c[4] + 8*c[3] + 4*c[2] + 2*c[1] + c[0], "R4 count");
  endtask

  function automatic int lone_pos(input logic [NE-1:0] v);
    for (int j = 0; j < NE; j++) if (v[j]) return j;
    return -1;
  endfunction

  initial begin : watchdog
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [NE-1:0] seen;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    dem_en_i = 1'b1;
    msb_i    = '1;
    ptr_m    = 5'd1;
    repeat (3) @(negedge clk);
    check_eq(unit_o, '0, "R1 reset clears drives");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 seed: pointer 1 puts the single LSB element on line 0
    step(5'b00001, 1'b0, 1'b1, "R1 seed pointer");
    check_int(lone_pos(unit_o), 0, "R1 seed position");

    // R5 fixed allotment, several words
    step(5'b10000, 1'b0, 1'b0, "R5 msb only");
    check_eq(unit_o, 31'h0000_FFFF, "R5 msb run 0-15");
    step(5'b00010, 1'b0, 1'b0, "R5 bit1");
    check_eq(unit_o, 31'h3000_0000, "R5 bit1 run 28-29");
    step(5'b01101, 1'b0, 1'b0, "R5 mixed");
    step(5'b11111, 1'b0, 1'b0, "R5 all ones");
    step(5'b00000, 1'b0, 1'b0, "R5 all zero");

    // R2: walk the whole pointer cycle with one element
    seen = '0;
    for (int k = 0; k < NE; k++) begin
      step(5'b00001, 1'b1, 1'b1, "R2 walk");
      if (lone_pos(unit_o) >= 0) seen[lone_pos(unit_o)] = 1'b1;
    end
    check_eq(seen, '1, "R2 all 31 rotations visited");
    check_int(int'(ptr_m), 1, "R2 model period returns to seed");
    step(5'b00001, 1'b0, 1'b1, "R2 back at seed");
    check_int(lone_pos(unit_o), 0, "R2 period 31 at ports");

    // R3: no strobe, allotment frozen over a conversion
    for (int k = 0; k < 8; k++) step(5'b10110, 1'b0, 1'b1, "R3 hold");

    // R7: strobe with new word; new pointer only from the following word
    step(5'b00001, 1'b1, 1'b1, "R7 strobe uses old pointer");
    check_int(lone_pos(unit_o), 0, "R7 old pointer position");
    step(5'b00001, 1'b0, 1'b1, "R7 next word uses new pointer");
    check_int(lone_pos(unit_o), 1, "R7 new pointer position");

    // R8: advance to pointer 31 (full turn) and to wrap cases
    while (ptr_m != 5'd31) step(5'b10000, 1'b1, 1'b1, "R8 advance");
    step(5'b10000, 1'b0, 1'b1, "R8 pointer 31");
    check_eq(unit_o, 31'h0000_FFFF, "R8 pointer 31 equals no turn");
    while (ptr_m != 5'd20) step(5'b10000, 1'b1, 1'b1, "R8 advance");
    step(5'b10000, 1'b0, 1'b1, "R8 wrap msb run");
    check_eq(unit_o, 31'h7FF0_001F, "R8 run 20-30 then 0-4");

    // R6: random words, random strobes, random mode
    for (int k = 0; k < 300; k++) begin
      step(NB'($urandom), 1'($urandom), ($urandom % 4) != 0, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule